// File: doc/BRIEF.md
# Alternate ALU Operand Latch

This datapath slice belongs to a small 8-bit accumulator machine. It holds a working register W, a register file, Z and C flags, and an ALU. It also adds a spare 8-bit operand latch. Two prefix opcodes fill this latch, either from an immediate byte or from any register-file entry, and the value passes through the ALU on the way in. For the single instruction that follows a prefix, the ALU reads the latch instead of W as its source operand. A two-word pair can therefore perform `reg = src`, `reg = reg + src`, `reg = reg - src` or `reg = reg + constant` and leave W untouched.

The fetch unit presents one decoded opcode per cycle, together with a register address, an immediate byte and a pending-interrupt request. A small sequencer has three states. In ST_RUN, instructions execute normally and interrupts are accepted. ST_ARMED follows a prefix: the latch is the source operand and interrupts are held off. ST_SKIP is the annulled slot that follows a taken test-and-skip.

The transitions are as follows:
- ST_RUN goes to ST_ARMED on a prefix.
- ST_RUN and ST_ARMED go to ST_SKIP on a taken skip.
- ST_ARMED stays in ST_ARMED on a chained prefix and returns to ST_RUN on any other opcode.
- ST_SKIP always returns to ST_RUN.
- An acknowledged interrupt keeps the sequencer in ST_RUN.

Top module: `alt_operand_slice`

## Requirements
- R1: After reset, W is 0, Z and C are 0, every register-file entry is 0, and no writeback is signalled.
- R2: Opcode encoding on `op_i`: 0 NOP, 1 LDW (W = imm), 2 LATK (latch = imm), 3 LATF (latch = reg[addr]), 4 MOVF (reg[addr] = src), 5 ADDF (reg[addr] = reg[addr] + src), 6 SUBF (reg[addr] = reg[addr] - src), 7 RDW (W = reg[addr]), 8 SKPZ (skip the next slot if src is 0). All other codes act as NOP. Here src is W, unless a prefix executed in the previous slot.
- R3: The prefixes LATK and LATF load the latch. They change neither W, the flags nor the register file, and they assert no writeback.
- R4: The instruction in the slot right after a prefix uses the latch as src. MOVF, ADDF, SUBF, SKPZ and NOP executed there leave W unchanged.
- R5: Substitution lasts exactly one slot, whether or not that slot writes back (NOP and SKPZ also consume it). A prefix in that slot reloads the latch and arms again.
- R6: ADDF sets C to the carry out. SUBF sets C to 1 when no borrow occurs. ADDF, SUBF, MOVF and RDW set Z when their 8-bit result is 0. MOVF and RDW keep C. NOP, LDW and SKPZ keep both flags.
- R7: In ST_RUN with `irq_req_i` high, `irq_ack_o` is high and the presented instruction is not executed. In ST_ARMED and ST_SKIP, `irq_ack_o` stays low and no interrupt is taken.
- R8: A SKPZ whose src is 0 annuls the next slot. That slot writes nothing, changes no state and does not arm, even if it holds a prefix. A SKPZ with a non-zero src skips nothing.
- R9: `wb_en_o`, `wb_addr_o` and `wb_data_o` show the register write of the current slot combinationally. W and the flags change at the clock edge that ends the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Decoded opcode of the current slot |
| addr_i | input | AW (4) | Register-file address |
| imm_i | input | DW (8) | Immediate byte |
| irq_req_i | input | 1 | Interrupt pending |
| irq_ack_o | output | 1 | Interrupt taken in this slot; instruction not executed |
| wb_en_o | output | 1 | Register write in this slot |
| wb_addr_o | output | AW (4) | Register write address |
| wb_data_o | output | DW (8) | Register write data |
| w_o | output | DW (8) | Working register W |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry / no-borrow flag |

## Verification
The assertions take for granted that the fetch unit presents a valid opcode in every cycle and that it replays any instruction whose slot was given to an interrupt. The properties therefore relate prefix slots to the following slot without any gap cycles. The stimulus drives exactly one opcode per clock and never holds the fetch unit idle. It re-presents a prefix after an acknowledged interrupt, as the fetch unit would, and raises the interrupt request only in slots where the expected sequencer state is known.

// File: rtl/alt_operand_pkg.sv
package alt_operand_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDW  = 4'd1,
        OP_LATK = 4'd2,
        OP_LATF = 4'd3,
        OP_MOVF = 4'd4,
        OP_ADDF = 4'd5,
        OP_SUBF = 4'd6,
        OP_RDW  = 4'd7,
        OP_SKPZ = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_SKIP  = 2'd2
    } seq_state_e;

    function automatic logic is_prefix(input logic [3:0] op);
        return (op == OP_LATK) || (op == OP_LATF);
    endfunction

endpackage

// File: rtl/alt_regfile.sv
module alt_regfile #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/alt_alu.sv
module alt_alu
    import alt_operand_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] regv,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] res,
    output logic          cy
);
    logic [DW:0] ext;

    always_comb begin
        ext = '0;
        res = '0;
        cy  = 1'b0;
        unique case (op)
            OP_LDW, OP_LATK: res = imm;
            OP_LATF, OP_RDW: res = regv;
            OP_MOVF, OP_SKPZ: res = src;
            OP_ADDF: begin
                ext = {1'b0, regv} + {1'b0, src};
                res = ext[DW-1:0];
                cy  = ext[DW];
            end
            OP_SUBF: begin
                ext = {1'b0, regv} - {1'b0, src};
                res = ext[DW-1:0];
                cy  = ~ext[DW];
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alt_seq.sv
module alt_seq
    import alt_operand_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] op,
    input  logic       src_zero,
    input  logic       irq_req,
    output logic       exec,
    output logic       use_latch,
    output logic       irq_ack
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (irq_req)                             st_d = ST_RUN;
                else if (is_prefix(op))                  st_d = ST_ARMED;
                else if (op == OP_SKPZ && src_zero)      st_d = ST_SKIP;
                else                                     st_d = ST_RUN;
            end
            ST_ARMED: begin
                if (is_prefix(op))                       st_d = ST_ARMED;
                else if (op == OP_SKPZ && src_zero)      st_d = ST_SKIP;
                else                                     st_d = ST_RUN;
            end
            ST_SKIP:                                     st_d = ST_RUN;
            default:                                     st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        exec      = 1'b0;
        use_latch = 1'b0;
        irq_ack   = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                irq_ack = irq_req;
                exec    = ~irq_req;
            end
            ST_ARMED: begin
                exec      = 1'b1;
                use_latch = 1'b1;
            end
            ST_SKIP: ;
            default: ;
        endcase
    end

    // R8: the slot after a taken skip is never an armed slot
    a_r8_skip_not_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SKIP) |=> (st_q == ST_RUN));

endmodule

// File: rtl/alt_operand_slice.sv
module alt_operand_slice
    import alt_operand_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] imm_i,
    input  logic          irq_req_i,
    output logic          irq_ack_o,
    output logic          wb_en_o,
    output logic [AW-1:0] wb_addr_o,
    output logic [DW-1:0] wb_data_o,
    output logic [DW-1:0] w_o,
    output logic          z_o,
    output logic          c_o
);
    logic [DW-1:0] w_q, lat_q, src, regv, res;
    logic          z_q, c_q, cy;
    logic          exec, use_latch, src_zero;
    logic          wr_w, wr_lat, wr_z, wr_c, wr_rf;

    assign src      = use_latch ? lat_q : w_q;
    assign src_zero = (res == '0);

    alt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_i),
        .src_zero  (src_zero),
        .irq_req   (irq_req_i),
        .exec      (exec),
        .use_latch (use_latch),
        .irq_ack   (irq_ack_o)
    );

    alt_alu #(.DW(DW)) u_alu (
        .op   (op_i),
        .src  (src),
        .regv (regv),
        .imm  (imm_i),
        .res  (res),
        .cy   (cy)
    );

    alt_regfile #(.DW(DW), .AW(AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_rf),
        .addr  (addr_i),
        .wdata (res),
        .rdata (regv)
    );

    always_comb begin
        wr_rf  = 1'b0;
        wr_w   = 1'b0;
        wr_lat = 1'b0;
        wr_z   = 1'b0;
        wr_c   = 1'b0;
        if (exec) begin
            unique case (op_i)
                OP_LDW:           wr_w = 1'b1;
                OP_LATK, OP_LATF: wr_lat = 1'b1;
                OP_MOVF: begin wr_rf = 1'b1; wr_z = 1'b1; end
                OP_ADDF, OP_SUBF: begin wr_rf = 1'b1; wr_z = 1'b1; wr_c = 1'b1; end
                OP_RDW:  begin wr_w = 1'b1; wr_z = 1'b1; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q   <= '0;
            lat_q <= '0;
            z_q   <= 1'b0;
            c_q   <= 1'b0;
        end else begin
            if (wr_w)   w_q   <= res;
            if (wr_lat) lat_q <= res;
            if (wr_z)   z_q   <= src_zero;
            if (wr_c)   c_q   <= cy;
        end
    end

    assign wb_en_o   = wr_rf;
    assign wb_addr_o = addr_i;
    assign wb_data_o = res;
    assign w_o       = w_q;
    assign z_o       = z_q;
    assign c_o       = c_q;

    // R3: an executed prefix leaves W and flags as they were
    a_r3_prefix_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && is_prefix(op_i)) |=> ($stable(w_o) && $stable(z_o) && $stable(c_o)));

    // R4: a substituted consumer does not touch W
    a_r4_consumer_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
        (use_latch && (op_i == OP_MOVF || op_i == OP_ADDF || op_i == OP_SUBF ||
                       op_i == OP_SKPZ || op_i == OP_NOP)) |=> $stable(w_o));

    // R5: substitution lasts one slot unless re-armed by a prefix
    a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (use_latch && !is_prefix(op_i)) |=> !use_latch);

    // R3: an executed prefix arms the following slot
    a_r3_prefix_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && is_prefix(op_i)) |=> use_latch);

    // R7: no interrupt entry while armed
    a_r7_no_ack_armed: assert property (@(posedge clk) disable iff (!rst_n)
        use_latch |-> !irq_ack_o);

    // R8: a taken skip annuls the next slot
    a_r8_skip_annuls: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_i == OP_SKPZ && src_zero) |=> (!wb_en_o && !use_latch && !irq_ack_o));

endmodule

// File: tb/tb_alt_operand_slice.sv
module tb_alt_operand_slice;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [3:0] addr_i = '0;
    logic [7:0] imm_i = '0;
    logic       irq_req_i = 1'b0;
    logic       irq_ack_o, wb_en_o, z_o, c_o;
    logic [3:0] wb_addr_o;
    logic [7:0] wb_data_o, w_o;

    int checks = 0;
    int failures = 0;
    logic       s_ack, s_wben;
    logic [7:0] s_wbdata;

    always #2 clk = ~clk;

    alt_operand_slice dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .imm_i(imm_i),
        .irq_req_i(irq_req_i), .irq_ack_o(irq_ack_o), .wb_en_o(wb_en_o),
        .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o), .w_o(w_o), .z_o(z_o), .c_o(c_o)
    );

    localparam logic [3:0] NOP = 4'd0, LDW = 4'd1, LATK = 4'd2, LATF = 4'd3,
        MOVF = 4'd4, ADDF = 4'd5, SUBF = 4'd6, RDW = 4'd7, SKPZ = 4'd8;

    // op, addr, imm, irq, exp_ack, exp_wben, exp_wbdata, exp_w, exp_z, exp_c
    localparam int NV = 17;
    localparam logic [36:0] VEC [NV] = '{
        {LDW,  4'd0, 8'h05, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05, 1'b0, 1'b0},
        {MOVF, 4'd1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h05, 8'h05, 1'b0, 1'b0},
        {LATK, 4'd0, 8'h0A, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05, 1'b0, 1'b0},
        {MOVF, 4'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'h0A, 8'h05, 1'b0, 1'b0},
        {LATF, 4'd1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05, 1'b0, 1'b0},
        {ADDF, 4'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h05, 1'b0, 1'b0},
        {ADDF, 4'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'h14, 8'h05, 1'b0, 1'b0},
        {LATK, 4'd0, 8'hEC, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05, 1'b0, 1'b0},
        {ADDF, 4'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h05, 1'b1, 1'b1},
        {LATK, 4'd0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05, 1'b1, 1'b1},
        {SUBF, 4'd1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h04, 8'h05, 1'b0, 1'b1},
        {SUBF, 4'd1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h05, 1'b0, 1'b0},
        {RDW,  4'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
        {LATK, 4'd0, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
        {LATK, 4'd0, 8'h33, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
        {MOVF, 4'd3, 8'h00, 1'b1, 1'b0, 1'b1, 8'h33, 8'h00, 1'b0, 1'b0},
        {NOP,  4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [3:0] a,
                        input logic [7:0] imm, input logic irq);
        @(negedge clk);
        op_i = op; addr_i = a; imm_i = imm; irq_req_i = irq;
        #1;
        s_ack = irq_ack_o; s_wben = wb_en_o; s_wbdata = wb_data_o;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 w", 16'(w_o), 16'h00);
        chk("R1 z", 16'(z_o), 16'h0);
        chk("R1 c", 16'(c_o), 16'h0);
        chk("R1 wb_en", 16'(wb_en_o), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7 R9 table
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][36:33], VEC[i][32:29], VEC[i][28:21], VEC[i][20]);
            chk($sformatf("R7 ack v%0d", i), 16'(s_ack), 16'(VEC[i][19]));
            chk($sformatf("R9 wb_en v%0d", i), 16'(s_wben), 16'(VEC[i][18]));
            if (VEC[i][18])
                chk($sformatf("R4 wb_data v%0d", i), 16'(s_wbdata), 16'(VEC[i][17:10]));
            chk($sformatf("R3 w v%0d", i), 16'(w_o), 16'(VEC[i][9:2]));
            chk($sformatf("R6 z v%0d", i), 16'(z_o), 16'(VEC[i][1]));
            chk($sformatf("R6 c v%0d", i), 16'(c_o), 16'(VEC[i][0]));
        end

        // R1 register file cleared: reg5 never written reads 0
        step(RDW, 4'd5, 8'h00, 1'b0);
        chk("R1 reg5 zero", 16'(w_o), 16'h00);
        chk("R1 reg5 z", 16'(z_o), 16'h1);

        // R5 NOP consumes substitution
        step(LDW, 4'd0, 8'h42, 1'b0);
        step(LATK, 4'd0, 8'h77, 1'b0);
        step(NOP, 4'd0, 8'h00, 1'b0);
        step(MOVF, 4'd4, 8'h00, 1'b0);
        chk("R5 nop consumes", 16'(s_wbdata), 16'h42);

        // R5 chained prefix reloads latch
        step(LATK, 4'd0, 8'h11, 1'b0);
        step(LATK, 4'd0, 8'h22, 1'b0);
        step(MOVF, 4'd9, 8'h00, 1'b0);
        chk("R5 chained", 16'(s_wbdata), 16'h22);
        chk("R4 chained w", 16'(w_o), 16'h42);

        // R8 skip on zero latch, skipped prefix does not arm
        step(LDW, 4'd0, 8'h09, 1'b0);
        step(LATK, 4'd0, 8'h00, 1'b0);
        step(SKPZ, 4'd0, 8'h00, 1'b0);
        chk("R4 skpz keeps w", 16'(w_o), 16'h09);
        step(LATK, 4'd0, 8'h55, 1'b1);
        chk("R8 skipped no wb", 16'(s_wben), 16'h0);
        chk("R7 no ack in skip", 16'(s_ack), 16'h0);
        step(MOVF, 4'd7, 8'h00, 1'b0);
        chk("R8 skipped prefix not armed", 16'(s_wbdata), 16'h09);

        // R8 non-zero src does not skip; R5 SKPZ consumes substitution
        step(LDW, 4'd0, 8'h00, 1'b0);
        step(LATK, 4'd0, 8'h03, 1'b0);
        step(SKPZ, 4'd0, 8'h00, 1'b0);
        step(MOVF, 4'd8, 8'h00, 1'b0);
        chk("R8 no skip wb_en", 16'(s_wben), 16'h1);
        chk("R5 skpz consumes", 16'(s_wbdata), 16'h00);

        // R8 W zero skips the following write
        step(SKPZ, 4'd0, 8'h00, 1'b0);
        step(MOVF, 4'd8, 8'h00, 1'b0);
        chk("R8 w zero skip", 16'(s_wben), 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule